// File: doc/BRIEF.md
# Prioritized UART Interrupt Controller

This block collects the four interrupt causes of a serial port: receive errors, receive data waiting, transmit buffer empty and modem line change. It keeps one pending flag per cause, masks the flags with a four-bit enable register and drives a single active-high interrupt line to the processor. Each flag is set by its own event input and cleared by the one bus access that services it. The transmit-empty flag has a second clear path. Reading the identification register clears it, but only while it is the cause being reported.

Software reads an identification byte to learn why the line is raised. Bit 0 is a "nothing pending" flag. Bits 2:1 name the most urgent enabled cause. The byte is frozen at the first cycle of a read strobe, so a cause that arrives during a long read does not corrupt the value returned. The raw pending flags are also brought out, so the state of masked causes can be seen.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A synchronous reset clears all pending flags and enables. After reset the identification byte reads 0x01, the interrupt line is low and the enable readback is 0x00.
- R2: Among enabled pending causes the identification byte reports only the most urgent. The order from most to least urgent is line error, receive data, transmit empty, modem change. Bits 2:1 are 11 for line error, 10 for receive data, 01 for transmit empty and 00 for modem change, so the byte reads 0x06, 0x04, 0x02 or 0x00.
- R3: Identification bit 0 is 0 while an enabled cause is pending and 1 otherwise. The interrupt output is high exactly when bit 0 would be 0.
- R4: Identification bits 7:3 and enable readback bits 7:4 always read 0.
- R5: The enable write uses bit 0 for receive data, bit 1 for transmit empty, bit 2 for line error and bit 3 for modem change. A disabled cause neither raises the interrupt nor appears in the identification byte. Its pending flag still sets, and pending_flags uses the same bit order.
- R6: A line-error pulse sets the line-error flag. A line-status read clears it.
- R7: A rising edge on the receive-available level sets the receive-data flag. A receive-buffer read clears it. A level that stays high does not set the flag again.
- R8: A transmit-empty event sets the transmit-empty flag. A transmit-holding write clears it.
- R9: An identification read clears the transmit-empty flag only when the byte captured by that read is 0x02. When a more urgent cause is being reported, the read leaves the transmit-empty flag set.
- R10: A modem-change pulse sets the modem flag. A modem-status read clears it.
- R11: While the identification read strobe stays high, the read data keeps the value captured in its first cycle, even if causes are set or cleared meanwhile.
- R12: When a set event and its clearing access occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_err_pulse | input | 1 | One-cycle pulse on a receive error (overrun, parity, framing, break) |
| rx_avail | input | 1 | Level, high while received data waits |
| tx_empty_evt | input | 1 | One-cycle pulse when the transmit holding buffer empties |
| modem_chg_pulse | input | 1 | One-cycle pulse on a modem input change |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | DATA_W | Enable register write data |
| id_rd | input | 1 | Identification register read strobe, may last several cycles |
| lstat_rd | input | 1 | Line-status read strobe |
| rxbuf_rd | input | 1 | Receive-buffer read strobe |
| txhold_wr | input | 1 | Transmit-holding write strobe |
| mstat_rd | input | 1 | Modem-status read strobe |
| irq | output | 1 | Interrupt request, active high |
| id_rdata | output | DATA_W | Identification byte |
| en_rdata | output | DATA_W | Enable register readback |
| pending_flags | output | 4 | Raw pending flags, enable-bit order |

## Verification
The hardest case to reach is the conditional transmit-empty clear. An identification read must happen once while a more urgent cause hides the transmit-empty flag, and again after that cause is gone. The stimulus stacks all four causes first, then services them one at a time with the matching strobes. It issues identification reads between those accesses, and in one of them a new line error arrives while the strobe is held for a second cycle. Masked-cause behaviour is reached by rewriting the enables to one bit at a time while flags are left pending.

// File: rtl/uic_pkg.sv
package uic_pkg;
   localparam int N_SRC = 4;
   localparam int IDX_W = 2;

   // enable-bit positions (also pending_flags positions)
   localparam int EN_RDA  = 0;
   localparam int EN_THRE = 1;
   localparam int EN_LS   = 2;
   localparam int EN_MS   = 3;

   // priority slots, 0 is most urgent
   typedef enum logic [IDX_W-1:0] {
      SLOT_LS   = 2'd0,
      SLOT_RDA  = 2'd1,
      SLOT_THRE = 2'd2,
      SLOT_MS   = 2'd3
   } slot_e;

   // identification code in bits 2:1 is the inverted slot index
   function automatic logic [IDX_W-1:0] slot_code(input logic [IDX_W-1:0] slot);
      return ~slot;
   endfunction
endpackage

// File: rtl/uic_src_flag.sv
module uic_src_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic clr_i,
   output logic pend_o
);
   logic pend_q;

   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk) begin
            if (rst)        pend_q <= 1'b0;
            else if (set_i) pend_q <= 1'b1;
            else if (clr_i) pend_q <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk) begin
            if (rst)        pend_q <= 1'b0;
            else if (clr_i) pend_q <= 1'b0;
            else if (set_i) pend_q <= 1'b1;
         end
      end
   endgenerate

   assign pend_o = pend_q;
endmodule

// File: rtl/uic_prio_enc.sv
module uic_prio_enc #(
   parameter int N     = 4,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/uic_id_capture.sv
module uic_id_capture #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          rd_i,
   input  logic [DW-1:0] live_i,
   output logic          first_o,
   output logic [DW-1:0] rdata_o
);
   logic          rd_q;
   logic [DW-1:0] hold_q;

   assign first_o = rd_i & ~rd_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_q   <= 1'b0;
         hold_q <= '0;
      end else begin
         rd_q <= rd_i;
         if (first_o) hold_q <= live_i;
      end
   end

   assign rdata_o = (rd_i & ~first_o) ? hold_q : live_i;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
   parameter int DATA_W   = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              line_err_pulse,
   input  logic              rx_avail,
   input  logic              tx_empty_evt,
   input  logic              modem_chg_pulse,
   input  logic              en_wr,
   input  logic [DATA_W-1:0] en_wdata,
   input  logic              id_rd,
   input  logic              lstat_rd,
   input  logic              rxbuf_rd,
   input  logic              txhold_wr,
   input  logic              mstat_rd,
   output logic              irq,
   output logic [DATA_W-1:0] id_rdata,
   output logic [DATA_W-1:0] en_rdata,
   output logic [3:0]        pending_flags
);
   import uic_pkg::*;

   localparam int N   = N_SRC;
   localparam int IW  = IDX_W;
   localparam int PAD = DATA_W - N;
   localparam int IDPAD = DATA_W - (IW + 1);

   generate
      if (DATA_W < N || DATA_W < IW + 1) begin : g_bad_width
         $error("uart_irq_ctrl: DATA_W too small");
      end
      if (N != 4) begin : g_bad_count
         $error("uart_irq_ctrl: exactly four sources supported");
      end
   endgenerate

   // enable register
   logic [N-1:0] en_q;
   always_ff @(posedge clk) begin
      if (rst)        en_q <= '0;
      else if (en_wr) en_q <= en_wdata[N-1:0];
   end
   assign en_rdata = {{PAD{1'b0}}, en_q};

   // receive-available edge detect
   logic rx_q;
   always_ff @(posedge clk) begin
      if (rst) rx_q <= 1'b0;
      else     rx_q <= rx_avail;
   end

   // identification path
   logic [N-1:0]      pend;
   logic [N-1:0]      masked;
   logic [N-1:0]      slot_req;
   logic              any_pend;
   logic [IW-1:0]     top_slot;
   logic [DATA_W-1:0] id_live;
   logic              rd_first;

   assign masked = pend & en_q;

   assign slot_req[SLOT_LS]   = masked[EN_LS];
   assign slot_req[SLOT_RDA]  = masked[EN_RDA];
   assign slot_req[SLOT_THRE] = masked[EN_THRE];
   assign slot_req[SLOT_MS]   = masked[EN_MS];

   uic_prio_enc #(.N(N), .IDX_W(IW)) u_enc (
      .req_i (slot_req),
      .any_o (any_pend),
      .idx_o (top_slot)
   );

   assign id_live = {{IDPAD{1'b0}},
                     (any_pend ? slot_code(top_slot) : {IW{1'b0}}),
                     ~any_pend};

   uic_id_capture #(.DW(DATA_W)) u_cap (
      .clk     (clk),
      .rst     (rst),
      .rd_i    (id_rd),
      .live_i  (id_live),
      .first_o (rd_first),
      .rdata_o (id_rdata)
   );

   // per-source set and clear
   logic [N-1:0] set_v;
   logic [N-1:0] clr_v;
   logic         thre_reported;

   assign thre_reported = any_pend && (top_slot == SLOT_THRE);

   assign set_v[EN_RDA]  = rx_avail & ~rx_q;
   assign clr_v[EN_RDA]  = rxbuf_rd;
   assign set_v[EN_THRE] = tx_empty_evt;
   assign clr_v[EN_THRE] = txhold_wr | (rd_first & thre_reported);
   assign set_v[EN_LS]   = line_err_pulse;
   assign clr_v[EN_LS]   = lstat_rd;
   assign set_v[EN_MS]   = modem_chg_pulse;
   assign clr_v[EN_MS]   = mstat_rd;

   generate
      for (genvar s = 0; s < N; s++) begin : g_src
         uic_src_flag #(.SET_WINS(SET_WINS)) u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_v[s]),
            .clr_i  (clr_v[s]),
            .pend_o (pend[s])
         );
      end
   endgenerate

   assign irq           = any_pend;
   assign pending_flags = pend;
endmodule

// File: rtl/uic_checker.sv
module uic_checker #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst,
   input logic          irq,
   input logic [DW-1:0] id_rdata,
   input logic [DW-1:0] en_rdata,
   input logic [3:0]    pending_flags,
   input logic          id_rd,
   input logic          lstat_rd,
   input logic          line_err_pulse,
   input logic          txhold_wr,
   input logic          tx_empty_evt,
   input logic          mstat_rd,
   input logic          modem_chg_pulse
);
   assert_irq_tracks_id_R3: assert property (@(posedge clk) disable iff (rst)
      !id_rd |-> (irq == !id_rdata[0]));

   assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (id_rdata[DW-1:3] == '0) && (en_rdata[DW-1:4] == '0));

   assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      (en_rdata[3:0] == 4'b0) |-> !irq);

   assert_lerr_sets_R6: assert property (@(posedge clk) disable iff (rst)
      line_err_pulse |=> pending_flags[2]);

   assert_lstat_clears_R6: assert property (@(posedge clk) disable iff (rst)
      (lstat_rd && !line_err_pulse) |=> !pending_flags[2]);

   assert_txwr_clears_R8: assert property (@(posedge clk) disable iff (rst)
      (txhold_wr && !tx_empty_evt) |=> !pending_flags[1]);

   assert_mstat_clears_R10: assert property (@(posedge clk) disable iff (rst)
      (mstat_rd && !modem_chg_pulse) |=> !pending_flags[3]);

   assert_read_frozen_R11: assert property (@(posedge clk) disable iff (rst)
      (id_rd && $past(id_rd)) |-> $stable(id_rdata));
endmodule

bind uart_irq_ctrl uic_checker #(.DW(DATA_W)) u_chk (
   .clk             (clk),
   .rst             (rst),
   .irq             (irq),
   .id_rdata        (id_rdata),
   .en_rdata        (en_rdata),
   .pending_flags   (pending_flags),
   .id_rd           (id_rd),
   .lstat_rd        (lstat_rd),
   .line_err_pulse  (line_err_pulse),
   .txhold_wr       (txhold_wr),
   .tx_empty_evt    (tx_empty_evt),
   .mstat_rd        (mstat_rd),
   .modem_chg_pulse (modem_chg_pulse)
);

// File: tb/uart_irq_ctrl_bench.sv
`timescale 1ns/1ps
module uart_irq_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       line_err_pulse = 0, rx_avail = 0, tx_empty_evt = 0, modem_chg_pulse = 0;
   logic       en_wr = 0;
   logic [7:0] en_wdata = '0;
   logic       id_rd = 0, lstat_rd = 0, rxbuf_rd = 0, txhold_wr = 0, mstat_rd = 0;
   logic       irq;
   logic [7:0] id_rdata, en_rdata;
   logic [3:0] pending_flags;

   always #2.5 clk = ~clk;

   uart_irq_ctrl u_uart_irq_ctrl (
      .clk(clk), .rst(rst),
      .line_err_pulse(line_err_pulse), .rx_avail(rx_avail),
      .tx_empty_evt(tx_empty_evt), .modem_chg_pulse(modem_chg_pulse),
      .en_wr(en_wr), .en_wdata(en_wdata),
      .id_rd(id_rd), .lstat_rd(lstat_rd), .rxbuf_rd(rxbuf_rd),
      .txhold_wr(txhold_wr), .mstat_rd(mstat_rd),
      .irq(irq), .id_rdata(id_rdata), .en_rdata(en_rdata),
      .pending_flags(pending_flags)
   );

   typedef struct {
      string      tag;
      logic [7:0] id;
      logic       irq;
      logic [3:0] pend;
      logic [7:0] en;
      int         cyc;
   } exp_t;

   exp_t sbq[$];
   int   cnt = 0;
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   finished = 0;

   // monitor: compares queued expectations one time unit after each edge
   always @(posedge clk) begin
      #1;
      cnt++;
      while (sbq.size() > 0 && sbq[0].cyc <= cnt) begin
         exp_t e;
         e = sbq.pop_front();
         n_cmp++;
         if (id_rdata !== e.id || irq !== e.irq || pending_flags !== e.pend || en_rdata !== e.en) begin
            n_bad++;
            $display("FAIL %s: got id=%02h irq=%b pend=%04b en=%02h, expected id=%02h irq=%b pend=%04b en=%02h",
                     e.tag, id_rdata, irq, pending_flags, en_rdata, e.id, e.irq, e.pend, e.en);
         end
      end
   end

   // driver helpers
   task automatic expect_next(input string tag, input logic [7:0] id, input logic irq_e,
                              input logic [3:0] pend, input logic [7:0] en);
      exp_t e;
      e.tag = tag; e.id = id; e.irq = irq_e; e.pend = pend; e.en = en; e.cyc = cnt + 1;
      sbq.push_back(e);
   endtask

   task automatic nxt();
      @(negedge clk);
      line_err_pulse = 0; tx_empty_evt = 0; modem_chg_pulse = 0;
      en_wr = 0; id_rd = 0; lstat_rd = 0; rxbuf_rd = 0; txhold_wr = 0; mstat_rd = 0;
   endtask

   task automatic wr_en(input logic [7:0] v);
      en_wr = 1; en_wdata = v;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      expect_next("R1 reset state", 8'h01, 0, 4'b0000, 8'h00);

      nxt(); line_err_pulse = 1;
      expect_next("R5 flag sets while disabled", 8'h01, 0, 4'b0100, 8'h00);

      nxt(); wr_en(8'hFF);
      expect_next("R4 R2 enable all, line error reported", 8'h06, 1, 4'b0100, 8'h0F);

      nxt(); tx_empty_evt = 1; modem_chg_pulse = 1;
      expect_next("R8 R10 sets under line error", 8'h06, 1, 4'b1110, 8'h0F);

      nxt(); rx_avail = 1;
      expect_next("R7 rising edge sets rda", 8'h06, 1, 4'b1111, 8'h0F);

      nxt(); id_rd = 1;
      expect_next("R9 id read with line error keeps thre", 8'h06, 1, 4'b1111, 8'h0F);

      nxt(); lstat_rd = 1;
      expect_next("R6 R2 line-status read, rda reported", 8'h04, 1, 4'b1011, 8'h0F);

      nxt(); rxbuf_rd = 1;
      expect_next("R7 buffer read clears, level high no reset", 8'h02, 1, 4'b1010, 8'h0F);

      nxt(); rx_avail = 0; id_rd = 1;
      expect_next("R9 id read reporting thre clears it", 8'h02, 1, 4'b1000, 8'h0F);

      nxt(); id_rd = 1; line_err_pulse = 1;
      expect_next("R11 held read stays frozen", 8'h02, 1, 4'b1100, 8'h0F);

      nxt();
      expect_next("R2 line error after read", 8'h06, 1, 4'b1100, 8'h0F);

      nxt(); lstat_rd = 1; line_err_pulse = 1;
      expect_next("R12 set beats clear", 8'h06, 1, 4'b1100, 8'h0F);

      nxt(); lstat_rd = 1;
      expect_next("R2 modem code", 8'h00, 1, 4'b1000, 8'h0F);

      nxt(); mstat_rd = 1;
      expect_next("R10 modem read clears, R3 idle", 8'h01, 0, 4'b0000, 8'h0F);

      nxt(); wr_en(8'h02);
      expect_next("R5 thre-only enable", 8'h01, 0, 4'b0000, 8'h02);

      nxt(); rx_avail = 1;
      expect_next("R5 rda masked", 8'h01, 0, 4'b0001, 8'h02);

      nxt(); tx_empty_evt = 1;
      expect_next("R5 thre enabled reported", 8'h02, 1, 4'b0011, 8'h02);

      nxt(); txhold_wr = 1;
      expect_next("R8 holding write clears", 8'h01, 0, 4'b0001, 8'h02);

      nxt(); txhold_wr = 1; tx_empty_evt = 1;
      expect_next("R12 thre set beats write", 8'h02, 1, 4'b0011, 8'h02);

      nxt(); wr_en(8'h08);
      expect_next("R5 modem-only enable", 8'h01, 0, 4'b0011, 8'h08);

      nxt(); modem_chg_pulse = 1;
      expect_next("R5 modem enabled reported", 8'h00, 1, 4'b1011, 8'h08);

      nxt(); wr_en(8'hF4);
      expect_next("R4 R5 line-only enable, upper bits dropped", 8'h01, 0, 4'b1011, 8'h04);

      nxt(); line_err_pulse = 1;
      expect_next("R5 line error enabled", 8'h06, 1, 4'b1111, 8'h04);

      nxt(); wr_en(8'h01);
      expect_next("R5 rda-only enable", 8'h04, 1, 4'b1111, 8'h01);

      nxt(); rxbuf_rd = 1;
      expect_next("R7 rda cleared, others masked", 8'h01, 0, 4'b1110, 8'h01);

      nxt(); rst = 1;
      expect_next("R1 reset mid-run", 8'h01, 0, 4'b0000, 8'h00);

      nxt(); rst = 0;
      nxt(); nxt();
      if (sbq.size() != 0) begin
         n_bad++;
         $display("FAIL R1: %0d expectations left unchecked, expected 0", sbq.size());
      end
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule